// File: doc/BRIEF.md
# High-Side Switch Fault Supervisor

This block is the digital protection and diagnostic controller for one high-side N-channel gate driver. It receives the standby control, the switch command and a set of comparator flags from the analog front end. The flags cover over-voltage, a shallow and a deep under-voltage level, over-temperature, over-current, drain-source error, open load and load shorted to supply. From these it decides whether the gate may be driven. It issues a normal turn-off command and a fast turn-off command, selects what the diagnostic pin presents, and tells the over-current comparator which threshold to apply.

The faults fall into two classes. Some recover on their own: over-voltage, shallow under-voltage and over-temperature switch the gate off only while they are present. The others latch the gate off and raise the diagnostic pin: deep under-voltage, filtered over-current and filtered drain-source error. A latch is released only by a falling edge of the command. That edge opens a clear window during which the command cannot switch the gate on.

Every input passes through a two-flop synchronizer. All delays are counted in clock ticks and set by parameters.

Top module: `hs_fault_supervisor`

## Requirements
- R1: With standby low, the gate enable is 0 and the diagnostic mode is LOW (0), whatever the other inputs are. No fault latch is set and no timer runs.
- R2: With standby high and no fault, the gate enable follows the command. When the gate is on, the diagnostic mode is SENSE (3). When the command is low, the diagnostic mode is LOW (0).
- R3: Over-voltage arriving while the command is high leaves the gate on for OV_MASK_CYC cycles and then turns it off, with the diagnostic mode LOW. If over-voltage is already present when the command rises, the gate stays off. The gate returns as soon as the flag clears.
- R4: Over-temperature turns the gate off at once, without a latch and without fast off, with the diagnostic mode LOW. Normal operation resumes when the flag clears.
- R5: Shallow under-voltage turns the gate off without a latch, with the diagnostic mode LOW. Normal operation resumes when the flag clears.
- R6: Deep under-voltage latches the gate off at once, asserts fast off and sets the diagnostic mode to HIGH (1).
- R7: Over-current acts only after OC_FILT_CYC consecutive cycles. A shorter pulse has no effect, and the count restarts from zero when the flag drops. On expiry the block latches the gate off, asserts fast off and sets the diagnostic mode to HIGH.
- R8: A drain-source error latches the gate off with the diagnostic mode HIGH after VDS_MASK_CYC consecutive cycles. If shallow under-voltage is present at the same time, the latch is set with no delay.
- R9: Whenever fast off is asserted, normal off is asserted too. Normal off is asserted whenever the gate enable is 0.
- R10: A latch is released only by a falling edge of the command. Toggling standby does not release it. After the release, a window of CLR_WAIT_CYC cycles keeps the gate off and the diagnostic mode HIGH, whatever the command does.
- R11: With the command low, an open load gives the diagnostic mode OPEN (2) and a supply short gives HIGH (1); the short wins when both are present. When the command rises, that indication is held for CLR_WAIT_CYC cycles before the mode returns to SENSE.
- R12: The threshold select is 2 (half threshold) while shallow under-voltage is present. Otherwise it is 1 (two-thirds threshold) while a drain-source error is present, and 0 (full threshold) in all other cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is the timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_i | input | 1 | Standby control, high = active |
| in_i | input | 1 | Switch command |
| ov_i | input | 1 | Over-voltage flag |
| uv5_i | input | 1 | Shallow under-voltage flag |
| uv3_i | input | 1 | Deep under-voltage flag |
| ot_i | input | 1 | Over-temperature flag |
| oc_i | input | 1 | Over-current flag |
| vds_i | input | 1 | Drain-source error flag |
| open_i | input | 1 | Open-load flag |
| vshort_i | input | 1 | Load-shorted-to-supply flag |
| gate_en_o | output | 1 | Gate drive enable |
| off_norm_o | output | 1 | Normal turn-off command |
| off_fast_o | output | 1 | Fast turn-off command |
| diag_mode_o | output | 2 | Diagnostic mode: 0 LOW, 1 HIGH, 2 OPEN, 3 SENSE |
| oc_thr_sel_o | output | 2 | Over-current threshold: 0 full, 1 two-thirds, 2 half |

## Verification
Random mixes of standby, command, over-temperature and shallow under-voltage exercise the plain gating and the threshold select. These mixes separate the faults that recover on their own from the latching ones, because none of them may leave a trace once removed. Directed runs hold each filtered flag just short of its delay and then beyond it. This distinguishes a filter that restarts from one that keeps accumulating, and an immediate trip from a masked one. The release sequences toggle standby and then the command, which shows that only a falling command edge frees the latch and that the clear window ignores a command that rises again.

// File: rtl/hs_fault_supervisor.sv
module hs_fault_supervisor #(
  parameter int OV_MASK_CYC  = 200,
  parameter int OC_FILT_CYC  = 3,
  parameter int VDS_MASK_CYC = 13000,
  parameter int CLR_WAIT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_i,
  input  logic       in_i,
  input  logic       ov_i,
  input  logic       uv5_i,
  input  logic       uv3_i,
  input  logic       ot_i,
  input  logic       oc_i,
  input  logic       vds_i,
  input  logic       open_i,
  input  logic       vshort_i,
  output logic       gate_en_o,
  output logic       off_norm_o,
  output logic       off_fast_o,
  output logic [1:0] diag_mode_o,
  output logic [1:0] oc_thr_sel_o
);

  localparam int NIN = 10;
  localparam int OVW = $clog2(OV_MASK_CYC + 1);
  localparam int OCW = $clog2(OC_FILT_CYC + 1);
  localparam int VDW = $clog2(VDS_MASK_CYC + 1);
  localparam int CLW = $clog2(CLR_WAIT_CYC + 1);
  localparam logic [OVW-1:0] OV_LAST = OVW'(OV_MASK_CYC - 1);
  localparam logic [OCW-1:0] OC_LAST = OCW'(OC_FILT_CYC - 1);
  localparam logic [VDW-1:0] VD_LAST = VDW'(VDS_MASK_CYC - 1);
  localparam logic [CLW-1:0] CL_LOAD = CLW'(CLR_WAIT_CYC);

  localparam logic [1:0] DG_LOW   = 2'd0;
  localparam logic [1:0] DG_HIGH  = 2'd1;
  localparam logic [1:0] DG_OPEN  = 2'd2;
  localparam logic [1:0] DG_SENSE = 2'd3;

  logic [NIN-1:0] raw, sy1, sy2;
  assign raw = {vshort_i, open_i, vds_i, oc_i, ot_i, uv3_i, uv5_i, ov_i, in_i, stby_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
    end
  end

  logic s_stby, s_in, s_ov, s_uv5, s_uv3, s_ot, s_oc, s_vds, s_open, s_short;
  assign {s_short, s_open, s_vds, s_oc, s_ot, s_uv3, s_uv5, s_ov, s_in, s_stby} = sy2;

  logic           in_d, latch_q, ov_hold;
  logic [OVW-1:0] ov_cnt;
  logic [OCW-1:0] oc_cnt;
  logic [VDW-1:0] vds_cnt;
  logic [CLW-1:0] clr_cnt, ld_tmr;
  logic [1:0]     ld_code, live_code;

  wire in_fall  = in_d & ~s_in;
  wire in_rise  = ~in_d & s_in;
  wire clr_busy = clr_cnt != '0;
  wire ld_busy  = ld_tmr != '0;

  wire oc_trip  = s_stby & s_oc & (oc_cnt == OC_LAST);
  wire vds_trip = s_stby & s_vds & (s_uv5 | (vds_cnt == VD_LAST));
  wire uv3_trip = s_stby & s_uv3;
  wire set_now  = uv3_trip | oc_trip | vds_trip;

  assign live_code = !s_stby ? DG_LOW : s_short ? DG_HIGH : s_open ? DG_OPEN : DG_LOW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_d    <= 1'b0;
      latch_q <= 1'b0;
      ov_hold <= 1'b0;
      ov_cnt  <= '0;
      oc_cnt  <= '0;
      vds_cnt <= '0;
      clr_cnt <= '0;
      ld_tmr  <= '0;
      ld_code <= DG_LOW;
    end else begin
      in_d <= s_in;

      if (set_now)      latch_q <= 1'b1;
      else if (in_fall) latch_q <= 1'b0;

      if (in_fall && latch_q) clr_cnt <= CL_LOAD;
      else if (clr_busy)      clr_cnt <= clr_cnt - 1'b1;

      ov_hold <= s_stby & s_ov & (ov_hold | ~s_in | (ov_cnt == OV_LAST));
      if (s_stby && s_ov && s_in && !ov_hold)
        ov_cnt <= (ov_cnt == OV_LAST) ? ov_cnt : ov_cnt + 1'b1;
      else
        ov_cnt <= '0;

      if (s_stby && s_oc)
        oc_cnt <= (oc_cnt == OC_LAST) ? oc_cnt : oc_cnt + 1'b1;
      else
        oc_cnt <= '0;

      if (s_stby && s_vds)
        vds_cnt <= (vds_cnt == VD_LAST) ? vds_cnt : vds_cnt + 1'b1;
      else
        vds_cnt <= '0;

      if (!s_in) ld_code <= live_code;

      if (!s_in || !s_stby)              ld_tmr <= '0;
      else if (in_rise && ld_code != DG_LOW) ld_tmr <= CL_LOAD;
      else if (ld_busy)                  ld_tmr <= ld_tmr - 1'b1;
    end
  end

  assign gate_en_o = s_stby & s_in & ~latch_q & ~set_now & ~clr_busy
                   & ~ov_hold & ~s_ot & ~s_uv5;
  assign off_norm_o = ~gate_en_o;
  assign off_fast_o = s_stby & (latch_q | set_now);

  always_comb begin
    if (!s_stby)                   diag_mode_o = DG_LOW;
    else if (latch_q || clr_busy)  diag_mode_o = DG_HIGH;
    else if (!s_in)                diag_mode_o = live_code;
    else if (ld_busy)              diag_mode_o = ld_code;
    else if (gate_en_o)            diag_mode_o = DG_SENSE;
    else                           diag_mode_o = DG_LOW;
  end

  assign oc_thr_sel_o = s_uv5 ? 2'd2 : s_vds ? 2'd1 : 2'd0;

endmodule

// File: rtl/hs_fault_supervisor_chk.sv
module hs_fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_stby,
  input logic       s_in,
  input logic       s_uv3,
  input logic       s_uv5,
  input logic       s_vds,
  input logic       in_d,
  input logic       latch_q,
  input logic       clr_busy,
  input logic       gate_en_o,
  input logic       off_norm_o,
  input logic       off_fast_o,
  input logic [1:0] diag_mode_o,
  input logic [1:0] oc_thr_sel_o
);

  a_r1_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    !s_stby |-> (!gate_en_o && diag_mode_o == 2'd0));

  a_r9_fast_with_norm: assert property (@(posedge clk) disable iff (!rst_n)
    off_fast_o |-> off_norm_o);

  a_r6_uv3_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (s_stby && s_uv3) |=> latch_q);

  a_r8_uv5_vds_now: assert property (@(posedge clk) disable iff (!rst_n)
    (s_stby && s_uv5 && s_vds) |=> latch_q);

  a_r6_latched_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (s_stby && latch_q) |-> (!gate_en_o && off_fast_o && diag_mode_o == 2'd1));

  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> ($past(in_d) && !$past(s_in)));

  a_r10_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_stby && clr_busy) |-> (!gate_en_o && diag_mode_o == 2'd1));

  a_r12_half_on_uv5: assert property (@(posedge clk) disable iff (!rst_n)
    s_uv5 |-> oc_thr_sel_o == 2'd2);

  a_r12_twothirds_on_vds: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vds && !s_uv5) |-> oc_thr_sel_o == 2'd1);

endmodule

bind hs_fault_supervisor hs_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_stby(s_stby), .s_in(s_in), .s_uv3(s_uv3),
  .s_uv5(s_uv5), .s_vds(s_vds), .in_d(in_d), .latch_q(latch_q),
  .clr_busy(clr_busy), .gate_en_o(gate_en_o), .off_norm_o(off_norm_o),
  .off_fast_o(off_fast_o), .diag_mode_o(diag_mode_o), .oc_thr_sel_o(oc_thr_sel_o)
);

// File: tb/tb_hs_fault_supervisor.sv
`timescale 1ns/1ps
module tb_hs_fault_supervisor;
  localparam int OVM = 10, OCF = 4, VDM = 20, CLW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 0, cmd = 0, ov = 0, uv5 = 0, uv3 = 0, ot = 0, oc = 0, vds = 0, opn = 0, vsh = 0;
  logic gate, offn, offf;
  logic [1:0] diag, thr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hs_fault_supervisor #(.OV_MASK_CYC(OVM), .OC_FILT_CYC(OCF), .VDS_MASK_CYC(VDM),
                        .CLR_WAIT_CYC(CLW)) dut (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .in_i(cmd), .ov_i(ov), .uv5_i(uv5),
    .uv3_i(uv3), .ot_i(ot), .oc_i(oc), .vds_i(vds), .open_i(opn), .vshort_i(vsh),
    .gate_en_o(gate), .off_norm_o(offn), .off_fast_o(offf),
    .diag_mode_o(diag), .oc_thr_sel_o(thr));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_gate(input logic s, input logic c, input logic t, input logic u);
    return int'(s & c & ~t & ~u);
  endfunction

  function automatic int exp_diag(input logic s, input logic g);
    return !s ? 0 : (g ? 3 : 0);
  endfunction

  task automatic release_latch();
    cmd = 0; step(4);
    cmd = 1; step(4);
    chk("R10 window ignores command: gate", int'(gate), 0);
    chk("R10 window diag high", int'(diag), 1);
    step(CLW + 4);
    chk("R10 gate back after window", int'(gate), 1);
    chk("R10 diag sense after window", int'(diag), 3);
  endtask

  initial begin
    void'($urandom(32'h1D5E_0A17));
    step(2);
    chk("R1 reset gate", int'(gate), 0);
    chk("R9 reset normal off", int'(offn), 1);
    chk("R1 reset diag", int'(diag), 0);
    rst_n = 1; step(4);
    chk("R1 standby gate", int'(gate), 0);
    cmd = 1; step(4);
    chk("R1 standby ignores command", int'(gate), 0);
    chk("R1 standby fast off", int'(offf), 0);

    stby = 1; step(4);
    chk("R2 on gate", int'(gate), 1);
    chk("R2 on diag sense", int'(diag), 3);
    chk("R9 normal off released", int'(offn), 0);
    cmd = 0; step(4);
    chk("R2 off gate", int'(gate), 0);
    chk("R2 off diag", int'(diag), 0);
    cmd = 1; step(4);

    ov = 1; step(OVM);
    chk("R3 gate held through mask", int'(gate), 1);
    step(4);
    chk("R3 gate off after mask", int'(gate), 0);
    chk("R3 diag low", int'(diag), 0);
    ov = 0; step(4);
    chk("R3 auto restore", int'(gate), 1);
    cmd = 0; ov = 1; step(4);
    cmd = 1; step(4);
    chk("R3 present at rise keeps off", int'(gate), 0);
    ov = 0; step(4);
    chk("R3 restore after rise", int'(gate), 1);

    ot = 1; step(4);
    chk("R4 gate off", int'(gate), 0);
    chk("R4 no fast off", int'(offf), 0);
    chk("R4 diag low", int'(diag), 0);
    ot = 0; step(4);
    chk("R4 resume", int'(gate), 1);

    uv5 = 1; step(4);
    chk("R5 gate off", int'(gate), 0);
    chk("R5 diag low", int'(diag), 0);
    chk("R12 half threshold", int'(thr), 2);
    uv5 = 0; step(4);
    chk("R5 resume", int'(gate), 1);
    chk("R12 full threshold", int'(thr), 0);

    uv3 = 1; step(4);
    chk("R6 gate latched off", int'(gate), 0);
    chk("R6 fast off", int'(offf), 1);
    chk("R9 normal with fast", int'(offn), 1);
    chk("R6 diag high", int'(diag), 1);
    uv3 = 0; stby = 0; step(4);
    chk("R1 standby masks diag", int'(diag), 0);
    stby = 1; step(4);
    chk("R10 standby does not release", int'(gate), 0);
    chk("R10 still diag high", int'(diag), 1);
    release_latch();

    oc = 1; step(OCF - 2); oc = 0; step(4);
    chk("R7 short pulse ignored", int'(gate), 1);
    chk("R7 short pulse diag", int'(diag), 3);
    oc = 1; step(OCF - 2); oc = 0; step(1); oc = 1; step(OCF - 2); oc = 0; step(4);
    chk("R7 filter restarts", int'(gate), 1);
    oc = 1; step(OCF + 4);
    chk("R7 trips after filter", int'(gate), 0);
    chk("R7 fast off", int'(offf), 1);
    chk("R7 diag high", int'(diag), 1);
    oc = 0; step(2);
    release_latch();

    vds = 1; step(VDM - 4);
    chk("R8 gate held through mask", int'(gate), 1);
    chk("R12 two-thirds threshold", int'(thr), 1);
    step(8);
    chk("R8 latched after mask", int'(gate), 0);
    chk("R8 diag high", int'(diag), 1);
    vds = 0; step(2);
    release_latch();
    vds = 1; uv5 = 1; step(4);
    chk("R12 uv5 wins", int'(thr), 2);
    vds = 0; uv5 = 0; step(4);
    chk("R8 immediate latch holds", int'(gate), 0);
    chk("R8 immediate diag", int'(diag), 1);
    release_latch();

    cmd = 0; opn = 1; step(4);
    chk("R11 open diag", int'(diag), 2);
    vsh = 1; step(4);
    chk("R11 short wins", int'(diag), 1);
    vsh = 0; step(4);
    cmd = 1; opn = 0; step(4);
    chk("R11 gate on during hold", int'(gate), 1);
    chk("R11 open held after rise", int'(diag), 2);
    step(CLW + 4);
    chk("R11 back to sense", int'(diag), 3);

    for (int i = 0; i < 60; i++) begin
      stby = 1'($urandom_range(0, 3) != 0);
      cmd  = 1'($urandom_range(0, 1));
      ot   = 1'($urandom_range(0, 3) == 0);
      uv5  = 1'($urandom_range(0, 3) == 0);
      step(4);
      chk("R2 random gate", int'(gate), exp_gate(stby, cmd, ot, uv5));
      chk("R2 random diag", int'(diag), exp_diag(stby, 1'(exp_gate(stby, cmd, ot, uv5))));
      chk("R12 random threshold", int'(thr), uv5 ? 2 : 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule